// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block models a single-port synchronous SRAM with a pipelined read path and an internal burst address generator. Every address and control input is sampled on the rising clock edge. A burst begins when either of two address strobes is asserted. The processor strobe `adsp_n` only acts while `ce1_n` is low. The controller strobe `adsc_n` acts on its own. After a burst starts, a two-bit counter supplies the next three addresses while `adv_n` is held low. The `order_sel` input picks between XOR (interleaved) and wrap-around (linear) order.

Each word is split into byte lanes. A write can be global, covering every lane, or per lane, covering only the selected lanes. Read data passes through an array register and then an output register.

Read data leaves on `rdata`, qualified by `rdata_valid`. This output stream has no ready input and cannot be stalled. The consumer must take each word in the cycle that `rdata_valid` is high, and `rdata` keeps its last word otherwise. Pulling `sleep` high puts the block in a low-power state. In that state no access happens, the array keeps its contents and the burst state is frozen.

Top module: `burst_sram`

## Requirements
- R1: After reset, `rdata_valid` is 0 and `rdata` is 0.
- R2: A read performed at clock edge N shows its word on `rdata` with `rdata_valid` high after edge N+1. A write access or a cycle with no access gives `rdata_valid` low after edge N+1.
- R3: A strobe loads `addr` as the burst base, and the access at that edge uses `addr`. When `adsp_n` and `adsc_n` are both low with `ce1_n` low, the load is taken from the processor strobe.
- R4: `adsp_n` is ignored while `ce1_n` is high. If `adsc_n` is also high, an ongoing burst continues unchanged. If `adsc_n` is low, that strobe acts alone.
- R5: The device is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A strobe that finds the device unselected ends the burst, with no access at that edge or at later edges until the next selecting strobe. `rdata_valid` is low after the following edge.
- R6: During a burst with no strobe, `adv_n`=0 advances the counter and accesses the next burst address. `adv_n`=1 repeats the access at the current address. After the fourth address the sequence wraps back to the base.
- R7: With order 1 (interleaved), address bits [1:0] are the base bits [1:0] XOR the count 0..3.
- R8: With order 0 (linear), address bits [1:0] are the base bits [1:0] plus the count, modulo 4. The upper address bits stay at the base.
- R9: The order used by an access at edge N is the `order_sel` value sampled at edge N-1.
- R10: `gw_n`=0 writes all lanes, whatever `bwe_n` and `bw_n` are.
- R11: With `gw_n`=1 and `bwe_n`=0, every lane i whose `bw_n[i]` is 0 is written, where lane i is `wdata[9i+8:9i]`, and the other lanes keep their contents. If all `bw_n` bits are 1, the cycle is a read.
- R12: With `gw_n`=1 and `bwe_n`=1, the cycle is a read whatever `bw_n` is.
- R13: While `sleep` is 1 there is no access and no write. The burst base and counter hold, and `rdata_valid` is low after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of control and output state |
| addr | input | ADDR_W | External word address |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| order_sel | input | 1 | Burst order: 1 interleaved, 0 linear |
| sleep | input | 1 | Low-power hold |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_valid | output | 1 | Read data qualifier, no back-pressure |

## Verification
The bench uses the default parameters: ADDR_W=8, LANES=4 and LANE_W=9. With only 256 words, every word can be preloaded with a value derived from its own address. Any wrong burst address therefore shows up as a data mismatch. The 8-bit address leaves six upper bits above the counter, so the bench can confirm that a linear wrap keeps them fixed. Four 9-bit lanes make it possible to test a mix of written and untouched lanes in one word.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic [1:0] {
    STROBE_NONE = 2'd0,
    STROBE_PROC = 2'd1,
    STROBE_CTRL = 2'd2
  } strobe_e;

  // Low two address bits for burst position 'pos' from base bits 'base'.
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] pos,
                                           input logic       interleave);
    return interleave ? (base ^ pos) : (base + pos);
  endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic              sleep,
  output logic              acc_fire,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              desel
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              active_q;
  logic              order_q;

  strobe_e    kind;
  logic       strobe;
  logic       selected;
  logic       adv_step;
  logic [1:0] pos;

  always_comb begin
    if (!adsp_n && !ce1_n)  kind = STROBE_PROC;
    else if (!adsc_n)       kind = STROBE_CTRL;
    else                    kind = STROBE_NONE;
    strobe   = (kind != STROBE_NONE);
    selected = !ce1_n && ce2 && !ce3_n;
    adv_step = active_q && !strobe && !adv_n;
    pos      = adv_step ? cnt_q + 2'd1 : cnt_q;
    acc_fire = !sleep && (strobe ? selected : active_q);
    desel    = !sleep && strobe && !selected;
    acc_addr = strobe ? addr
                      : {base_q[ADDR_W-1:2], burst_low(base_q[1:0], pos, order_q)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      order_q  <= 1'b0;
    end else begin
      order_q <= order_sel;
      if (!sleep) begin
        if (strobe) begin
          active_q <= selected;
          base_q   <= addr;
          cnt_q    <= '0;
        end else if (adv_step) begin
          cnt_q <= cnt_q + 2'd1;
        end
      end
    end
  end

  // R13
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(base_q) && $stable(cnt_q) && $stable(active_q)));

  // R3
  load_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && selected && !sleep) |=> (cnt_q == 2'd0 && active_q && base_q == $past(addr)));

  // R6
  advance_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_step && !sleep) |=> (cnt_q == $past(cnt_q) + 2'd1));

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [LANES-1:0]        lane_en,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rd_q
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && lane_en[g])
        mem[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_en)
        rd_q[g*LANE_W +: LANE_W] <= mem[addr];
    end
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    order_sel,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_valid
);

  localparam int WORD_W = LANES * LANE_W;

  logic              acc_fire;
  logic [ADDR_W-1:0] acc_addr;
  logic              desel;
  logic              write_req;
  logic [LANES-1:0]  lane_en;
  logic              wr_fire;
  logic              rd_fire;
  logic              stage_v_q;
  logic [WORD_W-1:0] stage_q;

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .ce3_n     (ce3_n),
    .adsp_n    (adsp_n),
    .adsc_n    (adsc_n),
    .adv_n     (adv_n),
    .order_sel (order_sel),
    .sleep     (sleep),
    .acc_fire  (acc_fire),
    .acc_addr  (acc_addr),
    .desel     (desel)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_en
    assign lane_en[g] = !gw_n || (!bwe_n && !bw_n[g]);
  end

  assign write_req = |lane_en;
  assign wr_fire   = acc_fire && write_req;
  assign rd_fire   = acc_fire && !write_req;

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .we      (wr_fire),
    .lane_en (lane_en),
    .rd_en   (rd_fire),
    .addr    (acc_addr),
    .wdata   (wdata),
    .rd_q    (stage_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_v_q   <= 1'b0;
      rdata_valid <= 1'b0;
      rdata       <= '0;
    end else begin
      stage_v_q   <= rd_fire;
      rdata_valid <= stage_v_q;
      if (stage_v_q)
        rdata <= stage_q;
    end
  end

  // R5
  deselect_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> ##1 !rdata_valid);

  // R2
  valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> $past(rd_fire, 2));

  // R13
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ##1 !rdata_valid);

endmodule

// File: tb/burst_sram_bench.sv
`timescale 1ns/1ps
module burst_sram_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n;
  logic [3:0]  bw_n;
  logic        order_sel, sleep;
  logic [35:0] wdata, rdata;
  logic        rdata_valid;
  int          checks = 0;
  int          failures = 0;

  always #10 clk = ~clk;

  burst_sram u_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .order_sel(order_sel), .sleep(sleep), .wdata(wdata),
    .rdata(rdata), .rdata_valid(rdata_valid)
  );

  function automatic logic [35:0] pat(input logic [7:0] a);
    return {a, ~a, a, ~a, 4'h5};
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1;
    bw_n = 4'hF; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; sleep = 1'b0;
  endtask

  // Vector: {kind[1:0] (1 proc, 2 ctrl, 3 both), adv_n, order_sel, addr, exp_valid, exp_addr}
  localparam int NV = 16;
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00},  // idle, R2 no access
    {2'd1, 1'b1, 1'b1, 8'h16, 1'b1, 8'h16},  // R3 proc load
    {2'd0, 1'b0, 1'b1, 8'h00, 1'b1, 8'h17},  // R7 pos1
    {2'd0, 1'b0, 1'b1, 8'h00, 1'b1, 8'h14},  // R7 pos2
    {2'd0, 1'b1, 1'b1, 8'h00, 1'b1, 8'h14},  // R6 hold
    {2'd0, 1'b0, 1'b1, 8'h00, 1'b1, 8'h15},  // R7 pos3
    {2'd0, 1'b0, 1'b1, 8'h00, 1'b1, 8'h16},  // R6 wrap
    {2'd0, 1'b1, 1'b0, 8'h00, 1'b1, 8'h16},  // R6 hold
    {2'd2, 1'b1, 1'b0, 8'h2E, 1'b1, 8'h2E},  // R3 ctrl load
    {2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h2F},  // R8
    {2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h2C},  // R8 wrap, upper fixed
    {2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h2D},  // R8
    {2'd3, 1'b1, 1'b0, 8'h41, 1'b1, 8'h41},  // R3 both strobes
    {2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h42},  // R8
    {2'd0, 1'b1, 1'b0, 8'h00, 1'b1, 8'h42},  // R6 hold
    {2'd0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00}   // drain, unchecked
  };

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [35:0] e;
    quiet();
    addr = '0; wdata = '0; order_sel = 1'b0; rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 valid", {35'd0, rdata_valid}, 36'd0);
    chk("R1 data", rdata, 36'd0);

    for (int a = 0; a < 256; a++) begin
      quiet(); adsc_n = 1'b0; addr = a[7:0]; gw_n = 1'b0; wdata = pat(a[7:0]);
      tick();
    end
    quiet(); adsc_n = 1'b0; ce2 = 1'b0; tick();

    for (int i = 0; i < NV; i++) begin
      quiet();
      adsp_n = !(VEC[i][20:19] == 2'd1 || VEC[i][20:19] == 2'd3);
      adsc_n = !(VEC[i][20:19] == 2'd2 || VEC[i][20:19] == 2'd3);
      adv_n = VEC[i][18]; order_sel = VEC[i][17]; addr = VEC[i][16:9];
      tick();
      if (i > 0) begin
        chk("R2 table valid", {35'd0, rdata_valid}, {35'd0, VEC[i-1][8]});
        if (VEC[i-1][8]) chk("R6/R7/R8 table data", rdata, pat(VEC[i-1][7:0]));
      end
    end

    // R11 lanes 0 and 2 written
    quiet(); adsc_n = 1'b0; addr = 8'h10; bwe_n = 1'b0; bw_n = 4'b1010; wdata = '1; tick();
    quiet(); adsc_n = 1'b0; addr = 8'h10; tick();
    quiet(); tick();
    e = pat(8'h10); e[8:0] = '1; e[26:18] = '1;
    chk("R11 byte write", rdata, e);
    // R12 no byte enable -> read
    quiet(); adsc_n = 1'b0; addr = 8'h11; bw_n = 4'h0; wdata = '0; tick();
    quiet(); tick();
    chk("R12 read valid", {35'd0, rdata_valid}, 36'd1);
    chk("R12 data kept", rdata, pat(8'h11));
    // R11 all lane selects high -> read
    quiet(); adsc_n = 1'b0; addr = 8'h12; bwe_n = 1'b0; wdata = '0; tick();
    quiet(); tick();
    chk("R11 no lanes read", rdata, pat(8'h12));
    // R10 global write
    quiet(); adsc_n = 1'b0; addr = 8'h13; gw_n = 1'b0; bwe_n = 1'b0; bw_n = 4'b1110;
    wdata = 36'h123456789; tick();
    quiet(); adsc_n = 1'b0; addr = 8'h13; tick();
    chk("R2 write no valid", {35'd0, rdata_valid}, 36'd0);
    quiet(); tick();
    chk("R10 global write", rdata, 36'h123456789);

    // R5 deselect
    quiet(); adsc_n = 1'b0; addr = 8'h20; tick();
    quiet(); tick();
    chk("R5 before", rdata, pat(8'h20));
    quiet(); adsc_n = 1'b0; ce2 = 1'b0; tick();
    quiet(); tick();
    chk("R5 deselect valid", {35'd0, rdata_valid}, 36'd0);
    quiet(); tick();
    chk("R5 burst ended", {35'd0, rdata_valid}, 36'd0);

    // R4 proc strobe with ce1_n high
    quiet(); adsc_n = 1'b0; addr = 8'h30; tick();
    quiet(); adsp_n = 1'b0; ce1_n = 1'b1; addr = 8'h50; tick();
    quiet(); tick();
    chk("R4 ignored", rdata, pat(8'h30));
    quiet(); adsp_n = 1'b0; adsc_n = 1'b0; ce1_n = 1'b1; addr = 8'h50; tick();
    quiet(); tick();
    chk("R4 ctrl alone deselects", {35'd0, rdata_valid}, 36'd0);

    // R13 sleep
    order_sel = 1'b0;
    quiet(); adsc_n = 1'b0; addr = 8'h30; tick();
    quiet(); adv_n = 1'b0; tick();
    quiet(); sleep = 1'b1; adv_n = 1'b0; gw_n = 1'b0; wdata = '0; tick();
    quiet(); tick();
    chk("R13 sleep valid", {35'd0, rdata_valid}, 36'd0);
    quiet(); tick();
    chk("R13 held and unwritten", rdata, pat(8'h31));

    // R9 order latency
    order_sel = 1'b0;
    quiet(); tick();
    quiet(); adsc_n = 1'b0; addr = 8'h01; tick();
    quiet(); adv_n = 1'b0; tick();
    quiet(); adv_n = 1'b0; tick();
    quiet(); adv_n = 1'b0; order_sel = 1'b1; tick();
    quiet(); tick();
    chk("R9 old order", rdata, pat(8'h00));
    quiet(); tick();
    chk("R9 new order", rdata, pat(8'h02));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule